// File: doc/BRIEF.md
# Pipelined Multichannel ADC Scan Sequencer

This block is an SPI master that runs a scan of a multiplexed ADC whose conversion-start input is wired to the SPI chip select. Every 16-bit frame does two things at once: it returns the result of the conversion started by the previous frame, and its chip-select edge starts the next conversion. Results therefore arrive one frame late.

A trigger pulse latches the channel-enable mask. The block then sends one channel-select frame for each enabled channel, lowest channel first, and finishes with an all-zero frame that collects the last result. The word received in the first frame is left over from an earlier sequence and is dropped. Every later word is written through a result-write port into a dense slot index, and a one-cycle done pulse closes the scan. When the block is idle, a separate request sends a single frame that takes the converter out of its conversion mode.

Top module: `adc_scan_seq`

## Requirements
- R1: A scan over a mask with N set bits (N from 1 to 16) sends exactly N+1 frames of 16 SCLK rising edges each. There are N channel-select frames, then one closing frame.
- R2: The channel-select frame for channel c is the 16-bit word ((0x10 + c) << 3) << 8. Its upper byte carries the command and its lower byte is 0x00. The frames follow in ascending channel order.
- R3: The closing frame of every scan is the word 0x0000.
- R4: The word received in the first frame is discarded. The word received in frame k (k >= 1) is written with res_idx_o = k-1, so slots 0..N-1 hold the results of the active channels in ascending channel order.
- R5: CS_N stays high for at least CS_GAP clock cycles between any two frames.
- R6: The SPI link uses mode 0. SCLK is low whenever CS_N is high. MOSI changes only while SCLK is low, and words go MSB first. MISO is sampled on the SCLK rising edge, MSB first.
- R7: The mask is taken in the cycle the trigger is accepted. Changing chan_mask_i during a scan has no effect on that scan's frames or results.
- R8: A trigger that arrives while busy_o is high starts no scan and sends no frame. It sets overrun_o, which then stays high until reset.
- R9: A trigger with an all-zero mask sends no frame. It pulses scan_done_o for one cycle in the cycle after the trigger.
- R10: An exit request while idle sends the single frame 0x5000 and produces no result write and no done pulse.
- R11: scan_done_o pulses for one cycle, in the same cycle as the final result write of a non-empty scan. In the following cycle busy_o is low.
- R12: After reset, CS_N is high, SCLK is low, and busy_o, overrun_o, res_we_o and scan_done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Scan start pulse |
| chan_mask_i | input | NCH | Channel-enable mask, bit c enables channel c |
| exit_req_i | input | 1 | Request to send the leave-conversion-mode frame |
| sclk_o | output | 1 | SPI clock, mode 0 |
| cs_n_o | output | 1 | SPI chip select, also the conversion start |
| mosi_o | output | 1 | Serial command out |
| miso_i | input | 1 | Serial result in |
| res_we_o | output | 1 | Result write strobe |
| res_idx_o | output | IDXW | Dense result slot index |
| res_data_o | output | 16 | Result word |
| scan_done_o | output | 1 | One-cycle end-of-scan pulse |
| busy_o | output | 1 | Scan or exit frame in progress |
| overrun_o | output | 1 | Sticky flag for a trigger that arrived while busy |

## Verification
The scan is run on single-bit masks at both ends of the range, on the full mask, on a sparse checker pattern and on random non-empty masks. These separate the correct frame count and channel order from off-by-one errors at the lowest and highest channel. The ADC model returns words that encode the channel and the frame in which each conversion started, so a result that has not been shifted by one frame, or that lands in the wrong slot, shows up as a wrong data value. A mask flipped mid-scan, a second trigger during a scan, an empty mask and an exit request each test a path where the output must stay as if that stimulus had not happened.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int MAXCH   = 16;
  localparam int FRAME_W = 16;

  localparam logic [FRAME_W-1:0] NOOP_WORD = 16'h0000;
  localparam logic [FRAME_W-1:0] EXIT_WORD = 16'h5000;

  typedef enum logic [1:0] {C_IDLE, C_ISSUE, C_WAIT} ctrl_st_e;
  typedef enum logic [1:0] {E_IDLE, E_SHIFT, E_GAP} eng_st_e;

  // Index of the lowest set bit; zero for an empty mask.
  function automatic logic [3:0] lowest_ch(input logic [MAXCH-1:0] m);
    lowest_ch = '0;
    for (int i = MAXCH - 1; i >= 0; i--) begin
      if (m[i]) lowest_ch = 4'(i);
    end
  endfunction

  // Channel-select word: command byte high, zero pad low.
  function automatic logic [FRAME_W-1:0] sel_word(input logic [3:0] ch);
    logic [7:0] cmd;
    cmd = (8'h10 + {4'h0, ch}) << 3;
    return {cmd, 8'h00};
  endfunction

endpackage

// File: rtl/adc_spi_frame.sv
module adc_spi_frame #(
  parameter int HALF_DIV = 2,
  parameter int CS_GAP   = 4,
  parameter int FW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [FW-1:0] tx_i,
  output logic          ready_o,
  output logic          done_o,
  output logic [FW-1:0] rx_o,
  output logic          sclk_o,
  output logic          cs_n_o,
  output logic          mosi_o,
  input  logic          miso_i
);
  import adc_scan_pkg::*;

  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BW = $clog2(FW);
  localparam int GW = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;

  eng_st_e       st_q;
  logic [DW-1:0] div_q;
  logic [BW-1:0] bit_q;
  logic [GW-1:0] gap_q;
  logic [FW-1:0] tx_sh_q;
  logic [FW-1:0] rx_sh_q;
  logic          half_tick;

  assign half_tick = (div_q == DW'(HALF_DIV - 1));
  assign ready_o   = (st_q == E_IDLE);
  assign mosi_o    = tx_sh_q[FW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= E_IDLE;
      div_q   <= '0;
      bit_q   <= '0;
      gap_q   <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      rx_o    <= '0;
      done_o  <= 1'b0;
      sclk_o  <= 1'b0;
      cs_n_o  <= 1'b1;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        E_IDLE: begin
          if (start_i) begin
            cs_n_o  <= 1'b0;
            tx_sh_q <= tx_i;
            rx_sh_q <= '0;
            div_q   <= '0;
            bit_q   <= '0;
            sclk_o  <= 1'b0;
            st_q    <= E_SHIFT;
          end
        end
        E_SHIFT: begin
          if (!half_tick) begin
            div_q <= div_q + 1'b1;
          end else begin
            div_q <= '0;
            if (!sclk_o) begin
              sclk_o  <= 1'b1;
              rx_sh_q <= {rx_sh_q[FW-2:0], miso_i};
            end else begin
              sclk_o <= 1'b0;
              if (bit_q == BW'(FW - 1)) begin
                cs_n_o <= 1'b1;
                done_o <= 1'b1;
                rx_o   <= rx_sh_q;
                gap_q  <= '0;
                st_q   <= E_GAP;
              end else begin
                tx_sh_q <= {tx_sh_q[FW-2:0], 1'b0};
                bit_q   <= bit_q + 1'b1;
              end
            end
          end
        end
        E_GAP: begin
          if (gap_q >= GW'(CS_GAP - 1)) st_q <= E_IDLE;
          else gap_q <= gap_q + 1'b1;
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int NCH  = 16,
  parameter int FW   = 16,
  parameter int IDXW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_i,
  input  logic [NCH-1:0]  mask_i,
  input  logic            exit_req_i,
  input  logic            eng_ready_i,
  input  logic            eng_done_i,
  input  logic [FW-1:0]   eng_rx_i,
  output logic            eng_start_o,
  output logic [FW-1:0]   eng_tx_o,
  output logic            scan_start_o,
  output logic            res_we_o,
  output logic [IDXW-1:0] res_idx_o,
  output logic [FW-1:0]   res_data_o,
  output logic            scan_done_o,
  output logic            busy_o,
  output logic            overrun_o
);
  import adc_scan_pkg::*;

  localparam int FIW = $clog2(NCH + 2);

  ctrl_st_e       st_q;
  logic [NCH-1:0] rem_q;
  logic [FIW-1:0] fidx_q;
  logic           exit_q;
  logic           last_q;
  logic [3:0]     nxt_ch;
  logic           rem_empty;

  assign nxt_ch       = lowest_ch(MAXCH'(rem_q));
  assign rem_empty    = (rem_q == '0);
  assign busy_o       = (st_q != C_IDLE);
  assign eng_start_o  = (st_q == C_ISSUE) && eng_ready_i;
  assign scan_start_o = (st_q == C_IDLE) && trig_i && (mask_i != '0);

  always_comb begin
    if (exit_q)         eng_tx_o = EXIT_WORD;
    else if (rem_empty) eng_tx_o = NOOP_WORD;
    else                eng_tx_o = sel_word(nxt_ch);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= C_IDLE;
      rem_q       <= '0;
      fidx_q      <= '0;
      exit_q      <= 1'b0;
      last_q      <= 1'b0;
      res_we_o    <= 1'b0;
      res_idx_o   <= '0;
      res_data_o  <= '0;
      scan_done_o <= 1'b0;
      overrun_o   <= 1'b0;
    end else begin
      res_we_o    <= 1'b0;
      scan_done_o <= 1'b0;
      if (trig_i && busy_o) overrun_o <= 1'b1;
      unique case (st_q)
        C_IDLE: begin
          if (trig_i) begin
            if (mask_i == '0) begin
              scan_done_o <= 1'b1;
            end else begin
              rem_q  <= mask_i;
              fidx_q <= '0;
              st_q   <= C_ISSUE;
            end
          end else if (exit_req_i) begin
            exit_q <= 1'b1;
            st_q   <= C_ISSUE;
          end
        end
        C_ISSUE: begin
          if (eng_start_o) begin
            last_q <= rem_empty && !exit_q;
            if (!rem_empty && !exit_q) rem_q <= rem_q & ~(NCH'(1) << nxt_ch);
            st_q <= C_WAIT;
          end
        end
        C_WAIT: begin
          if (eng_done_i) begin
            if (exit_q) begin
              exit_q <= 1'b0;
              st_q   <= C_IDLE;
            end else begin
              if (fidx_q != '0) begin
                res_we_o   <= 1'b1;
                res_idx_o  <= IDXW'(fidx_q - 1'b1);
                res_data_o <= eng_rx_i;
              end
              fidx_q <= fidx_q + 1'b1;
              if (last_q) begin
                scan_done_o <= 1'b1;
                st_q        <= C_IDLE;
              end else begin
                st_q <= C_ISSUE;
              end
            end
          end
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NCH      = 16,
  parameter int HALF_DIV = 2,
  parameter int CS_GAP   = 4,
  parameter int IDXW     = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_i,
  input  logic [NCH-1:0]  chan_mask_i,
  input  logic            exit_req_i,
  output logic            sclk_o,
  output logic            cs_n_o,
  output logic            mosi_o,
  input  logic            miso_i,
  output logic            res_we_o,
  output logic [IDXW-1:0] res_idx_o,
  output logic [15:0]     res_data_o,
  output logic            scan_done_o,
  output logic            busy_o,
  output logic            overrun_o
);
  import adc_scan_pkg::*;

  logic               eng_start;
  logic               eng_ready;
  logic               eng_done;
  logic               scan_start;
  logic [FRAME_W-1:0] eng_tx;
  logic [FRAME_W-1:0] eng_rx;

  adc_spi_frame #(
    .HALF_DIV(HALF_DIV),
    .CS_GAP  (CS_GAP),
    .FW      (FRAME_W)
  ) u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(eng_start),
    .tx_i   (eng_tx),
    .ready_o(eng_ready),
    .done_o (eng_done),
    .rx_o   (eng_rx),
    .sclk_o (sclk_o),
    .cs_n_o (cs_n_o),
    .mosi_o (mosi_o),
    .miso_i (miso_i)
  );

  adc_scan_ctrl #(
    .NCH (NCH),
    .FW  (FRAME_W),
    .IDXW(IDXW)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_i      (trig_i),
    .mask_i      (chan_mask_i),
    .exit_req_i  (exit_req_i),
    .eng_ready_i (eng_ready),
    .eng_done_i  (eng_done),
    .eng_rx_i    (eng_rx),
    .eng_start_o (eng_start),
    .eng_tx_o    (eng_tx),
    .scan_start_o(scan_start),
    .res_we_o    (res_we_o),
    .res_idx_o   (res_idx_o),
    .res_data_o  (res_data_o),
    .scan_done_o (scan_done_o),
    .busy_o      (busy_o),
    .overrun_o   (overrun_o)
  );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int CS_GAP = 4,
  parameter int IDXW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sclk_o,
  input logic            cs_n_o,
  input logic            mosi_o,
  input logic            res_we_o,
  input logic [IDXW-1:0] res_idx_o,
  input logic            scan_done_o,
  input logic            busy_o,
  input logic            overrun_o,
  input logic            eng_start,
  input logic            scan_start
);
  localparam int HW = $clog2(CS_GAP + 1) + 1;

  logic [HW-1:0]   hi_cnt;
  logic [IDXW:0]   wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= HW'(CS_GAP);
    end else if (!cs_n_o) begin
      hi_cnt <= '0;
    end else if (hi_cnt < HW'(CS_GAP)) begin
      hi_cnt <= hi_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   wr_cnt <= '0;
    else if (scan_start)          wr_cnt <= '0;
    else if (res_we_o)            wr_cnt <= wr_cnt + 1'b1;
  end

  // R5: chip select high long enough before each new frame
  a_r5_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> hi_cnt >= HW'(CS_GAP));

  // R6: clock parked low while deselected
  a_r6_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  // R6: MOSI held while SCLK is high
  a_r6_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> $stable(mosi_o));

  // R4: slots are written densely from zero
  a_r4_dense_idx: assert property (@(posedge clk) disable iff (!rst_n)
    res_we_o |-> ({1'b0, res_idx_o} == wr_cnt));

  // R8: overrun flag is sticky
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);

  // R11: block is idle after the done pulse
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done_o |=> !busy_o);

  // R1: a frame starts only from a deselected link
  a_r1_start_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> cs_n_o);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(
  .CS_GAP(CS_GAP),
  .IDXW  (IDXW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sclk_o     (sclk_o),
  .cs_n_o     (cs_n_o),
  .mosi_o     (mosi_o),
  .res_we_o   (res_we_o),
  .res_idx_o  (res_idx_o),
  .scan_done_o(scan_done_o),
  .busy_o     (busy_o),
  .overrun_o  (overrun_o),
  .eng_start  (eng_start),
  .scan_start (scan_start)
);

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;

  localparam int NCH      = 16;
  localparam int HALF_DIV = 2;
  localparam int CS_GAP   = 4;
  localparam int IDXW     = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            trig_i = 1'b0;
  logic [NCH-1:0]  chan_mask_i = '0;
  logic            exit_req_i = 1'b0;
  logic            sclk_o, cs_n_o, mosi_o;
  logic            miso_i = 1'b0;
  logic            res_we_o;
  logic [IDXW-1:0] res_idx_o;
  logic [15:0]     res_data_o;
  logic            scan_done_o, busy_o, overrun_o;

  always #4 clk = ~clk;

  adc_scan_seq #(.NCH(NCH), .HALF_DIV(HALF_DIV), .CS_GAP(CS_GAP), .IDXW(IDXW)) u_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .chan_mask_i(chan_mask_i),
    .exit_req_i(exit_req_i), .sclk_o(sclk_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o),
    .miso_i(miso_i), .res_we_o(res_we_o), .res_idx_o(res_idx_o),
    .res_data_o(res_data_o), .scan_done_o(scan_done_o), .busy_o(busy_o),
    .overrun_o(overrun_o)
  );

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  // ADC model state
  logic [15:0] pend = 16'h0;
  logic [15:0] rxw  = 16'h0;
  int          bitc = 0;
  int          frame_no = 0;
  int          bad_bits = 0;
  logic [15:0] frames[$];

  // monitors
  int          widx[$];
  logic [15:0] wdat[$];
  int          done_cnt = 0;
  int          done_wr = -1;
  int          hi_run = 0;
  int          min_gap = 1000;
  bit          seen_frame = 0;
  int          idle_clk_bad = 0;
  bit          mon_on = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_sel(input int ch);
    return 16'((16 + ch) * 2048);
  endfunction

  // slave: MSB first, presented at CS fall and each SCLK fall
  initial forever begin
    @(negedge cs_n_o);
    bitc = 0; rxw = 16'h0; miso_i = pend[15];
  end
  initial forever begin
    @(posedge sclk_o);
    rxw = {rxw[14:0], mosi_o}; bitc++;
  end
  initial forever begin
    @(negedge sclk_o);
    if (!cs_n_o && bitc < 16) miso_i = pend[15 - bitc];
  end
  initial forever begin
    @(posedge cs_n_o);
    if (mon_on) begin
      frames.push_back(rxw);
      if (bitc != 16) bad_bits++;
      if (rxw[7:0] == 8'h00 && rxw[15] == 1'b1)
        pend = {rxw[14:11], 12'(frame_no)};
      else
        pend = 16'hE000 ^ 16'(frame_no);
      frame_no++;
    end
  end

  initial forever begin
    @(negedge clk);
    if (mon_on) begin
      if (res_we_o) begin widx.push_back(int'(res_idx_o)); wdat.push_back(res_data_o); end
      if (scan_done_o) begin
        if (done_cnt == 0) done_wr = widx.size();
        done_cnt++;
      end
      if (cs_n_o) begin
        hi_run++;
        if (sclk_o) idle_clk_bad++;
      end else if (hi_run > 0) begin
        if (seen_frame && hi_run < min_gap) min_gap = hi_run;
        seen_frame = 1; hi_run = 0;
      end
    end
  end

  task automatic clear_logs();
    frames.delete(); widx.delete(); wdat.delete();
    done_cnt = 0; done_wr = -1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk);
      if (done_cnt > 0) break;
    end
  endtask

  task automatic run_scan(input logic [15:0] m, input bit flip, input bit retrig, input string tag);
    int chs[$];
    int g0;
    clear_logs();
    g0 = frame_no;
    for (int i = 0; i < 16; i++) if (m[i]) chs.push_back(i);
    @(negedge clk); trig_i = 1'b1; chan_mask_i = m;
    @(negedge clk); trig_i = 1'b0;
    if (flip) chan_mask_i = ~m;
    if (retrig) begin
      repeat (40) @(negedge clk);
      trig_i = 1'b1; @(negedge clk); trig_i = 1'b0;
    end
    wait_done();
    repeat (200) @(negedge clk);
    chk(done_cnt == 1, {tag, " R11 one done pulse"}, done_cnt, 1);
    chk(frames.size() == chs.size() + 1, {tag, " R1 frame count"}, frames.size(), chs.size() + 1);
    for (int j = 0; j < chs.size() && j < frames.size(); j++)
      chk(frames[j] == exp_sel(chs[j]), {tag, " R2 select word"}, frames[j], exp_sel(chs[j]));
    if (frames.size() > chs.size())
      chk(frames[chs.size()] == 16'h0000, {tag, " R3 closing word"}, frames[chs.size()], 0);
    chk(widx.size() == chs.size(), {tag, " R4 write count"}, widx.size(), chs.size());
    for (int j = 0; j < chs.size() && j < widx.size(); j++) begin
      chk(widx[j] == j, {tag, " R4 slot index"}, widx[j], j);
      chk(wdat[j] == {4'(chs[j]), 12'(g0 + j)}, {tag, " R4 R6 result word"},
          wdat[j], {4'(chs[j]), 12'(g0 + j)});
    end
    chk(done_wr == chs.size(), {tag, " R11 done with last write"}, done_wr, chs.size());
    chk(!busy_o, {tag, " R11 idle after scan"}, busy_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] m;
    void'($urandom(32'd20531));
    repeat (3) @(negedge clk);
    chk(cs_n_o == 1'b1, "R12 cs_n after reset", cs_n_o, 1);
    chk(sclk_o == 1'b0, "R12 sclk after reset", sclk_o, 0);
    chk(busy_o == 1'b0 && overrun_o == 1'b0, "R12 busy/overrun after reset", {busy_o, overrun_o}, 0);
    chk(res_we_o == 1'b0 && scan_done_o == 1'b0, "R12 strobes after reset", {res_we_o, scan_done_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    mon_on = 1;

    run_scan(16'h0001, 0, 0, "lowest");
    run_scan(16'h8000, 0, 0, "highest");
    run_scan(16'hFFFF, 0, 0, "full");
    run_scan(16'hA5A5, 0, 0, "sparse");
    for (int r = 0; r < 12; r++) begin
      m = 16'($urandom());
      if (m == 16'h0) m = 16'h0100;
      run_scan(m, 0, 0, "random");
    end
    chk(overrun_o == 1'b0, "R8 no overrun on clean scans", overrun_o, 0);

    // R7: mask flipped mid-scan
    run_scan(16'h3C01, 1, 0, "R7 flip");
    chan_mask_i = '0;

    // R9: empty mask
    clear_logs();
    @(negedge clk); trig_i = 1'b1; chan_mask_i = 16'h0;
    @(negedge clk); trig_i = 1'b0;
    chk(scan_done_o == 1'b1, "R9 done pulse next cycle", scan_done_o, 1);
    @(negedge clk);
    chk(scan_done_o == 1'b0, "R9 done one cycle", scan_done_o, 0);
    repeat (150) @(negedge clk);
    chk(frames.size() == 0, "R9 no frames", frames.size(), 0);
    chk(widx.size() == 0, "R9 no writes", widx.size(), 0);

    // R10: exit request
    clear_logs();
    @(negedge clk); exit_req_i = 1'b1;
    @(negedge clk); exit_req_i = 1'b0;
    for (int i = 0; i < 2000 && busy_o; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(frames.size() == 1, "R10 single frame", frames.size(), 1);
    if (frames.size() > 0) chk(frames[0] == 16'h5000, "R10 exit word", frames[0], 16'h5000);
    chk(widx.size() == 0 && done_cnt == 0, "R10 no write no done", widx.size() + done_cnt, 0);

    // R8: trigger while busy
    run_scan(16'h0F0F, 0, 1, "R8 retrigger");
    chk(overrun_o == 1'b1, "R8 overrun set", overrun_o, 1);
    run_scan(16'h0006, 0, 0, "R8 after overrun");
    chk(overrun_o == 1'b1, "R8 overrun sticky", overrun_o, 1);

    chk(bad_bits == 0, "R1 16 clocks per frame", bad_bits, 0);
    chk(min_gap >= CS_GAP, "R5 cs high gap", min_gap, CS_GAP);
    chk(idle_clk_bad == 0, "R6 sclk low while deselected", idle_clk_bad, 0);

    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule